// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Station Address Assembly

This block reads 16-bit words from a three-wire serial EEPROM that uses 6-bit word addressing. It drives chip select, a shift clock and the device's serial input, and samples the device's serial output. The shift clock is derived from the system clock through a divide value that is captured when a read is accepted. Every phase of the serial clock, high or low, lasts the same whole number of system clocks.

Two requests are available. A single read fetches the word at a chosen address and presents it with a one-cycle strobe. An address fetch reads words 6, 7, 8 and 9 in turn and builds a 48-bit station address from them. The address is stored one bit out of place in those words: each 16-bit piece of the address is the low 15 bits of one word, with the top bit of the word before it placed under them. A done flag marks the assembled address as valid.

Top module: `eeprom_mac_reader`

## Requirements
- R1: An accepted read sends an 11-bit command, most significant bit first: two zero bits, then 1, 1, 0, then the 6 address bits from a5 down to a0. Each bit is placed on `ee_di` while `ee_sk` is low and chip select is high, and `ee_sk` is then raised. `ee_di` does not change while `ee_sk` is high.
- R2: With divide value D, every high phase of `ee_sk` lasts D+1 system clocks, and chip select stays high for 56*(D+1) clocks per word. D is captured when a request is accepted, and changes to `clk_div` during a read have no effect on that read.
- R3: `ee_sk` is high only while `ee_cs` is high.
- R4: After the command, 16 data bits are clocked in. Each is sampled from `ee_do` at the end of an `ee_sk` high phase, and the first bit sampled becomes bit 0 of the word.
- R5: When a word completes, `ee_cs`, `ee_sk` and `ee_di` are all low, and `word_valid` is high for exactly one cycle with the word on `word_data`. `word_data` holds until the next strobe.
- R6: `busy` rises in the cycle after an accepted request. For a single read it is low again in the cycle of the `word_valid` strobe. A `rd_start` or `mac_start` that arrives while `busy` is high is ignored: no command is sent and no result changes.
- R7: An accepted `mac_start` reads addresses 6, 7, 8 and 9, in that order, with one `word_valid` strobe per word.
- R8: Address byte k sits in `mac_addr[8k+7:8k]`. Byte 2i is {word(7+i)[6:0], word(6+i)[15]} and byte 2i+1 is word(7+i)[14:7], for i = 0..2. `busy` stays high through the fourth strobe. `mac_done` rises one cycle after that strobe, in the same cycle that `busy` falls, and is cleared by the next accepted `mac_start`.
- R9: If `rd_start` and `mac_start` are both high in a cycle where the block is idle, the address fetch is performed and the single read is dropped.
- R10: After reset, all serial lines, `busy`, `word_valid`, `mac_done`, `word_data` and `mac_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | 8 | Serial clock divide value D; each phase lasts D+1 clocks |
| rd_start | input | 1 | Request a single word read |
| rd_addr | input | 6 | Word address for a single read |
| mac_start | input | 1 | Request the station address fetch |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| busy | output | 1 | A request is in progress |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 16 | Last word read |
| mac_addr | output | 48 | Assembled station address |
| mac_done | output | 1 | Station address is valid |

## Verification
A single read and an address fetch can be requested in the same cycle. A new request can also arrive on the same edge that the sequencer launches its next word or while a read is still in flight. The bench provokes both cases. It raises `rd_start` together with `mac_start` while idle, and it raises both requests, with a changed divide value, in the middle of a read. A behavioural EEPROM model logs every command it decodes. The outcome is judged from that log (only the expected addresses, in order), from the returned word, from the measured clock phase lengths and from the state of `mac_done`.

// File: rtl/eemr_pkg.sv
package eemr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_GAP,
    ST_DAT_HI,
    ST_DAT_LO
  } eng_state_t;

  localparam logic [2:0] OP_READ = 3'b110;
  localparam int unsigned CMD_PAD = 2;
endpackage

// File: rtl/eemr_tick.sv
module eemr_tick #(
  parameter int unsigned DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            run,
  input  logic [DIVW-1:0] div_in,
  output logic            tick
);
  logic [DIVW-1:0] div_q, div_d;
  logic [DIVW-1:0] cnt_q, cnt_d;

  always_comb begin
    div_d = load ? div_in : div_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == div_q) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && (cnt_q == div_q);

  // R2: the phase counter never passes the captured divide value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_q));
endmodule

// File: rtl/eemr_engine.sv
module eemr_engine
  import eemr_pkg::*;
#(
  parameter int unsigned ADDRW = 6,
  parameter int unsigned WORDW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ADDRW-1:0] addr,
  input  logic             tick,
  input  logic             ee_do,
  output logic             active,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  output logic             word_valid,
  output logic [WORDW-1:0] word_data
);
  localparam int unsigned CMDW = CMD_PAD + 3 + ADDRW;
  localparam int unsigned MAXN = (WORDW > CMDW) ? WORDW : CMDW;
  localparam int unsigned CNTW = $clog2(MAXN);

  eng_state_t       state_q, state_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [CMDW-1:0]  cmd_q, cmd_d;
  logic [WORDW-1:0] shf_q, shf_d;
  logic [WORDW-1:0] word_q, word_d;
  logic             valid_q, valid_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cmd_d   = cmd_q;
    shf_d   = shf_q;
    word_d  = word_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETUP;
        cnt_d   = '0;
        cmd_d   = {{CMD_PAD{1'b0}}, OP_READ, addr};
      end
      ST_SETUP:  if (tick) state_d = ST_CMD_LO;
      ST_CMD_LO: if (tick) state_d = ST_CMD_HI;
      ST_CMD_HI: if (tick) begin
        cmd_d = {cmd_q[CMDW-2:0], 1'b0};
        if (cnt_q == CNTW'(CMDW-1)) begin
          cnt_d   = '0;
          state_d = ST_GAP;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_CMD_LO;
        end
      end
      ST_GAP:    if (tick) state_d = ST_DAT_HI;
      ST_DAT_HI: if (tick) begin
        shf_d   = {ee_do, shf_q[WORDW-1:1]};
        state_d = ST_DAT_LO;
      end
      ST_DAT_LO: if (tick) begin
        if (cnt_q == CNTW'(WORDW-1)) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
          word_d  = shf_q;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_DAT_HI;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      shf_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      shf_q   <= shf_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign active     = (state_q != ST_IDLE);
  assign ee_cs      = (state_q != ST_IDLE);
  assign ee_sk      = (state_q == ST_CMD_HI) || (state_q == ST_DAT_HI);
  assign ee_di      = ((state_q == ST_CMD_LO) || (state_q == ST_CMD_HI)) && cmd_q[CMDW-1];
  assign word_valid = valid_q;
  assign word_data  = word_q;

  // R3: shift clock only inside a selected access
  a_r3_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  // R1: data line held while the shift clock is high
  a_r1_di_stable_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  // R5: lines parked at the word strobe
  a_r5_idle_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (!ee_cs && !ee_sk && !ee_di));
  // R5: strobe lasts one cycle
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

// File: rtl/eemr_mac_seq.sv
module eemr_mac_seq #(
  parameter int unsigned ADDRW  = 6,
  parameter int unsigned WORDW  = 16,
  parameter int unsigned BASE   = 6,
  parameter int unsigned NWORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mac_start,
  input  logic                         eng_busy,
  input  logic                         word_valid,
  input  logic [WORDW-1:0]             word_data,
  output logic                         go,
  output logic [ADDRW-1:0]             go_addr,
  output logic                         seq_active,
  output logic [(NWORDS-1)*WORDW-1:0]  mac_addr,
  output logic                         mac_done
);
  localparam int unsigned IDXW   = $clog2(NWORDS);
  localparam int unsigned NCHUNK = NWORDS - 1;

  logic             act_q, act_d;
  logic [IDXW-1:0]  idx_q, idx_d;
  logic             msb_q, msb_d;
  logic             done_q, done_d;
  logic             accept, take;
  logic [WORDW-1:0] chunk_q [NCHUNK];

  assign accept = mac_start && !eng_busy && !act_q;
  assign take   = act_q && word_valid;
  assign go     = accept || (take && (idx_q != IDXW'(NWORDS-1)));
  assign go_addr = accept ? ADDRW'(BASE) : (ADDRW'(BASE) + ADDRW'(idx_q) + 1'b1);

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    msb_d  = msb_q;
    done_d = done_q;
    if (accept) begin
      act_d  = 1'b1;
      idx_d  = '0;
      done_d = 1'b0;
    end else if (take) begin
      msb_d = word_data[WORDW-1];
      idx_d = idx_q + 1'b1;
      if (idx_q == IDXW'(NWORDS-1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      msb_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      msb_q  <= msb_d;
      done_q <= done_d;
    end
  end

  for (genvar gi = 0; gi < NCHUNK; gi++) begin : g_chunk
    logic             we;
    logic [WORDW-1:0] nxt;
    assign we  = take && (idx_q == IDXW'(gi + 1));
    assign nxt = we ? {word_data[WORDW-2:0], msb_q} : chunk_q[gi];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chunk_q[gi] <= '0;
      else        chunk_q[gi] <= nxt;
    end
    assign mac_addr[gi*WORDW +: WORDW] = chunk_q[gi];
  end

  assign seq_active = act_q;
  assign mac_done   = done_q;

  // R8: done only rises at the close of a running fetch
  a_r8_done_after_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_done) |-> $past(seq_active));
  // R7: a new word is only launched while the engine is idle
  a_r7_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !eng_busy);
endmodule

// File: rtl/eeprom_mac_reader.sv
module eeprom_mac_reader #(
  parameter int unsigned DIVW      = 8,
  parameter int unsigned ADDRW     = 6,
  parameter int unsigned WORDW     = 16,
  parameter int unsigned MAC_BASE  = 6,
  parameter int unsigned MAC_WORDS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [DIVW-1:0]                   clk_div,
  input  logic                              rd_start,
  input  logic [ADDRW-1:0]                  rd_addr,
  input  logic                              mac_start,
  output logic                              ee_cs,
  output logic                              ee_sk,
  output logic                              ee_di,
  input  logic                              ee_do,
  output logic                              busy,
  output logic                              word_valid,
  output logic [WORDW-1:0]                  word_data,
  output logic [(MAC_WORDS-1)*WORDW-1:0]    mac_addr,
  output logic                              mac_done
);
  logic             eng_active, tick;
  logic             seq_go, seq_active, rd_go, eng_start;
  logic [ADDRW-1:0] seq_addr, eng_addr;

  assign busy      = eng_active || seq_active;
  assign rd_go     = rd_start && !busy && !mac_start;
  assign eng_start = rd_go || seq_go;
  assign eng_addr  = seq_go ? seq_addr : rd_addr;

  eemr_tick #(.DIVW(DIVW)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (eng_start),
    .run    (eng_active),
    .div_in (clk_div),
    .tick   (tick)
  );

  eemr_engine #(.ADDRW(ADDRW), .WORDW(WORDW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (eng_start),
    .addr       (eng_addr),
    .tick       (tick),
    .ee_do      (ee_do),
    .active     (eng_active),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .ee_di      (ee_di),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

  eemr_mac_seq #(.ADDRW(ADDRW), .WORDW(WORDW), .BASE(MAC_BASE), .NWORDS(MAC_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_start  (mac_start),
    .eng_busy   (eng_active),
    .word_valid (word_valid),
    .word_data  (word_data),
    .go         (seq_go),
    .go_addr    (seq_addr),
    .seq_active (seq_active),
    .mac_addr   (mac_addr),
    .mac_done   (mac_done)
  );

  // R9: a joint request from idle starts the fetch, not a single read
  a_r9_fetch_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && mac_start && !busy) |=> (seq_active && !mac_done));
  // R6: busy rises after any accepted request
  a_r6_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !busy) |=> busy);
endmodule

// File: tb/test_eeprom_mac_reader.sv
`timescale 1ns/1ps
module test_eeprom_mac_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd0;
  logic        rd_start = 1'b0;
  logic [5:0]  rd_addr = 6'd0;
  logic        mac_start = 1'b0;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic        busy, word_valid, mac_done;
  logic [15:0] word_data;
  logic [47:0] mac_addr;

  always #2.5 clk = ~clk;

  eeprom_mac_reader i_eeprom_mac_reader (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .rd_start(rd_start),
    .rd_addr(rd_addr), .mac_start(mac_start), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do), .busy(busy), .word_valid(word_valid),
    .word_data(word_data), .mac_addr(mac_addr), .mac_done(mac_done)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // EEPROM model
  logic [15:0] mem [64];
  logic [10:0] sh;
  int bitn = 0, datn = 0;
  int hdr_bad = 0;
  int log_n = 0;
  logic [5:0] log_addr [16];

  always @(posedge ee_sk) begin
    if (bitn < 11) begin
      sh = {sh[9:0], ee_di};
      bitn++;
      if (bitn == 11) begin
        if (sh[10:6] != 5'b00110) hdr_bad++;
        if (log_n < 16) log_addr[log_n] = sh[5:0];
        log_n++;
      end
    end else datn++;
  end
  always @(negedge ee_sk) begin
    if (bitn == 11 && datn < 16) ee_do = mem[sh[5:0]][datn];
  end
  always @(negedge ee_cs) begin
    bitn = 0; datn = 0; ee_do = 1'b0;
  end

  // line monitor
  int div_exp = 0, hi_len = 0, hi_runs = 0, hi_bad = 0;
  int cs_len = 0, last_cs_len = 0, sk_nocs = 0;
  always @(negedge clk) begin
    if (ee_sk && !ee_cs) sk_nocs++;
    if (ee_sk) hi_len++;
    else if (hi_len != 0) begin
      hi_runs++;
      if (hi_len != div_exp + 1) hi_bad++;
      hi_len = 0;
    end
    if (ee_cs) cs_len++;
    else if (cs_len != 0) begin
      last_cs_len = cs_len;
      cs_len = 0;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clr_mon();
    hi_runs = 0; hi_bad = 0; last_cs_len = 0; sk_nocs = 0; log_n = 0; hdr_bad = 0;
  endtask

  task automatic wait_strobe(output bit got);
    got = 0;
    for (int k = 0; k < 6000; k++) begin
      step();
      if (word_valid) begin got = 1; break; end
    end
  endtask

  function automatic logic [47:0] exp_mac();
    logic [47:0] m;
    for (int i = 0; i < 3; i++) begin
      m[16*i +: 8]     = {mem[7+i][6:0], mem[6+i][15]};
      m[16*i + 8 +: 8] = mem[7+i][14:7];
    end
    return m;
  endfunction

  task automatic t_reset();
    // R10
    chk(!ee_cs && !ee_sk && !ee_di, "R10", "lines after reset", {ee_cs, ee_sk, ee_di}, 0);
    chk(!busy && !word_valid && !mac_done, "R10", "flags after reset", {busy, word_valid, mac_done}, 0);
    chk(word_data == 0 && mac_addr == 0, "R10", "data after reset", {word_data, mac_addr}, 0);
  endtask

  task automatic t_single(input logic [5:0] a, input int d);
    bit got;
    logic [15:0] held;
    clr_mon();
    clk_div = 8'(d); div_exp = d; rd_addr = a; rd_start = 1'b1;
    step();
    rd_start = 1'b0;
    chk(busy, "R6", "busy after accept", busy, 1);
    wait_strobe(got);
    chk(got, "R5", "strobe seen", got, 1);
    chk(word_data == mem[a], "R4", "word value", word_data, mem[a]);
    chk(!busy, "R6", "busy low at strobe", busy, 0);
    chk(!ee_cs && !ee_sk && !ee_di, "R5", "lines at strobe", {ee_cs, ee_sk, ee_di}, 0);
    chk(log_n == 1 && log_addr[0] == a, "R1", "command address", log_addr[0], a);
    chk(hdr_bad == 0, "R1", "command header", hdr_bad, 0);
    chk(hi_bad == 0 && hi_runs == 27, "R2", "sk high phases", {hi_bad, hi_runs}, 27);
    chk(last_cs_len == 56 * (d + 1), "R2", "cs length", last_cs_len, 56 * (d + 1));
    chk(sk_nocs == 0, "R3", "sk without cs", sk_nocs, 0);
    held = word_data;
    step();
    chk(!word_valid, "R5", "strobe one cycle", word_valid, 0);
    repeat (5) step();
    chk(word_data == held, "R5", "word held", word_data, held);
  endtask

  task automatic t_ignore();
    bit got;
    clr_mon();
    clk_div = 8'd2; div_exp = 2; rd_addr = 6'd20; rd_start = 1'b1;
    step();
    rd_start = 1'b0;
    repeat (30) step();
    clk_div = 8'd7; rd_addr = 6'd33; rd_start = 1'b1; mac_start = 1'b1;
    step();
    rd_start = 1'b0; mac_start = 1'b0;
    wait_strobe(got);
    chk(got && word_data == mem[20], "R6", "first read unaffected", word_data, mem[20]);
    chk(hi_bad == 0, "R2", "divide change ignored", hi_bad, 0);
    repeat (400) step();
    chk(log_n == 1, "R6", "late requests dropped", log_n, 1);
    chk(!busy && !mac_done, "R6", "no fetch started", {busy, mac_done}, 0);
  endtask

  task automatic t_mac(input int d, input bit both);
    bit got;
    clr_mon();
    clk_div = 8'(d); div_exp = d; mac_start = 1'b1;
    if (both) begin rd_start = 1'b1; rd_addr = 6'd3; end
    step();
    mac_start = 1'b0; rd_start = 1'b0;
    chk(busy && !mac_done, "R8", "fetch start clears done", {busy, mac_done}, 2);
    for (int k = 0; k < 4; k++) begin
      wait_strobe(got);
      chk(got && word_data == mem[6+k], "R7", "fetch word", word_data, mem[6+k]);
      chk(busy && !mac_done, "R8", "busy through strobe", {busy, mac_done}, 2);
    end
    step();
    chk(mac_done && !busy, "R8", "done after last strobe", {mac_done, busy}, 2);
    chk(mac_addr == exp_mac(), "R8", "assembled address", mac_addr, exp_mac());
    chk(log_n == 4 && log_addr[0] == 6 && log_addr[1] == 7 && log_addr[2] == 8 && log_addr[3] == 9,
        both ? "R9" : "R7", "fetch order", log_n, 4);
    chk(hi_bad == 0 && hdr_bad == 0, "R2", "fetch phases", hi_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'((i * 16'h2F1B) ^ 16'h9C35);
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_single(6'd0, 0);
    t_single(6'd63, 3);
    t_single(6'd42, 1);
    t_ignore();
    mem[6] = 16'hC001; mem[7] = 16'h7F80; mem[8] = 16'h8421; mem[9] = 16'hFFFF;
    t_mac(1, 1'b0);
    mem[6] = 16'h1234; mem[7] = 16'hFEDC; mem[8] = 16'h0F0F; mem[9] = 16'h8000;
    t_mac(0, 1'b1);
    finish_run();
  end
endmodule